// File: doc/BRIEF.md
# Two-Word Instruction Sequencing Core

This block is a small execution core whose every instruction is a pair of consecutive 32-bit words in a local memory with a 16-bit word address space. The memory sits outside the core and is reached through two ports, A and B. Both ports read synchronously, and port A also writes. The core runs each instruction in a fixed ring of four phases. In the first phase it reads the two instruction words at the program counter and the word after it. In the second it reads two source operands, using the source fields as addresses. In the third it selects literals, tests the condition and evaluates a 32-bit ALU operation. In the fourth it writes the result to the destination address and updates the carry and zero flags.

The header word carries the operation, two flag-update enables, three literal selectors, a 5-bit condition and the destination address. The second word carries the two 16-bit source fields. A source can be its own memory word, a zero-extended 16-bit literal, or half of a joined 32-bit literal. Conditions cover both the flag state and comparisons between the two operand values. A jump operation loads the program counter from the first operand.

Top module: `dw_exec_core`

## Requirements
- R1: While reset (rst_n low) is held and in the first cycle after it, pc equals the RESET_PC parameter, c_flag and z_flag are 0, and a_we is 0.
- R2: Each instruction takes exactly four clocks. In its first cycle a_addr is pc and b_addr is pc+1. a_we can be high only in its fourth cycle, and then a_addr is the destination field.
- R3: The header word layout is: opcode in bits 31:26, carry-update enable in bit 25, zero-update enable in bit 24, S1-literal in bit 23, S2-literal in bit 22, joined-literal in bit 21, condition in bits 20:16, destination in bits 15:0. The second word holds S1 in bits 31:16 and S2 in bits 15:0.
- R4: When the S1-literal bit is set, operand A is S1 zero-extended to 32 bits. When the S2-literal bit is set, operand B is S2 zero-extended. Each bit acts independently of the other.
- R5: When the joined-literal bit is set, operand A is {S1,S2}, operand B is 0, and the two single-literal bits are ignored.
- R6: When a source has no literal bit set, its field is a memory address and the word stored there becomes the operand.
- R7: The opcodes are: 1 add A+B, 2 subtract A-B, 3 AND, 4 OR, 5 XOR, 6 shift A left by B[4:0], 7 shift A right logically by B[4:0], 8 move A, and 9 jump. Opcodes 1 to 8 write the 32-bit result to the destination.
- R8: For opcodes 1 to 8, the new Z is 1 exactly when the result is zero. The new C is the carry out of an add, the borrow of a subtract (A < B unsigned), and 0 for the other opcodes.
- R9: C changes only when bit 25 is set, Z changes only when bit 24 is set, and either changes only when the condition passes on an opcode from 1 to 8.
- R10: The condition codes are: 0 never, 1 always, 2 C, 3 not C, 4 Z, 5 not Z, 6 C or Z, 7 neither C nor Z, 8 A==B, 9 A!=B, 10 A>B, 11 A>=B, 12 A<B, 13 A<=B (all unsigned), 14 A>B signed, 15 A<B signed. Codes 16 to 31 never pass.
- R11: Opcode 0, opcodes 10 to 63, and any instruction whose condition fails write no memory and leave both flags unchanged. The program counter still advances by two.
- R12: After each instruction the program counter advances by PC_STEP (2), wrapping at 16 bits. A jump whose condition passes instead loads bits 15:0 of operand A, and it writes neither memory nor flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_addr | output | 16 | Port A address (read, or write in the last phase) |
| a_we | output | 1 | Port A write enable |
| a_wdata | output | 32 | Port A write data |
| a_rdata | input | 32 | Port A read data, valid one clock after the address |
| b_addr | output | 16 | Port B read address |
| b_rdata | input | 32 | Port B read data, valid one clock after the address |
| pc | output | 16 | Program counter |
| c_flag | output | 1 | Carry flag |
| z_flag | output | 1 | Zero flag |

## Verification
The bench builds the core with RESET_PC set to 16'h0040 and the default PC_STEP of 2, so reset visibly lands away from address zero. Its memory model keeps 1024 words and folds the upper address bits away. Because of this, a jump to 16'hFFFE executes real code and the step past it shows the 16-bit wrap to zero. The 16-bit literal fields also reach every comparison and signed-versus-unsigned corner directly.

// File: rtl/dwx_pkg.sv
package dwx_pkg;
  localparam int FIELD_W = 16;
  localparam int WORD_W  = 2 * FIELD_W;
  localparam int OPC_W   = 6;
  localparam int COND_W  = 5;
  localparam int SHAMT_W = $clog2(WORD_W);

  typedef logic [FIELD_W-1:0] addr_t;
  typedef logic [WORD_W-1:0]  word_t;

  typedef enum logic [1:0] {PH_FETCH, PH_OPER, PH_EVAL, PH_WRITE} phase_t;

  // header word, most significant field first
  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic              wc;
    logic              wz;
    logic              l1;
    logic              l2;
    logic              lj;
    logic [COND_W-1:0] cond;
    addr_t             dst;
  } head_t;

  typedef struct packed {
    addr_t s1;
    addr_t s2;
  } tail_t;

  typedef struct packed {
    word_t res;
    logic  carry;
    logic  alu;
  } alu_out_t;

  localparam logic [OPC_W-1:0] OPC_NOP = 6'd0;
  localparam logic [OPC_W-1:0] OPC_ADD = 6'd1;
  localparam logic [OPC_W-1:0] OPC_SUB = 6'd2;
  localparam logic [OPC_W-1:0] OPC_AND = 6'd3;
  localparam logic [OPC_W-1:0] OPC_OR  = 6'd4;
  localparam logic [OPC_W-1:0] OPC_XOR = 6'd5;
  localparam logic [OPC_W-1:0] OPC_SHL = 6'd6;
  localparam logic [OPC_W-1:0] OPC_SHR = 6'd7;
  localparam logic [OPC_W-1:0] OPC_MOV = 6'd8;
  localparam logic [OPC_W-1:0] OPC_JMP = 6'd9;

  localparam logic [COND_W-1:0] CND_NEVER  = 5'd0;
  localparam logic [COND_W-1:0] CND_ALWAYS = 5'd1;
  localparam logic [COND_W-1:0] CND_C      = 5'd2;
  localparam logic [COND_W-1:0] CND_NC     = 5'd3;
  localparam logic [COND_W-1:0] CND_Z      = 5'd4;
  localparam logic [COND_W-1:0] CND_NZ     = 5'd5;
  localparam logic [COND_W-1:0] CND_C_OR_Z = 5'd6;
  localparam logic [COND_W-1:0] CND_NC_NZ  = 5'd7;
  localparam logic [COND_W-1:0] CND_EQ     = 5'd8;
  localparam logic [COND_W-1:0] CND_NE     = 5'd9;
  localparam logic [COND_W-1:0] CND_UGT    = 5'd10;
  localparam logic [COND_W-1:0] CND_UGE    = 5'd11;
  localparam logic [COND_W-1:0] CND_ULT    = 5'd12;
  localparam logic [COND_W-1:0] CND_ULE    = 5'd13;
  localparam logic [COND_W-1:0] CND_SGT    = 5'd14;
  localparam logic [COND_W-1:0] CND_SLT    = 5'd15;

  // 32-bit evaluation; alu=0 marks an opcode that produces no result
  function automatic alu_out_t alu_eval(input logic [OPC_W-1:0] opc,
                                        input word_t a, input word_t b);
    alu_out_t o;
    logic [WORD_W:0] wide;
    o    = '0;
    wide = '0;
    o.alu = 1'b1;
    case (opc)
      OPC_ADD: begin
        wide    = {1'b0, a} + {1'b0, b};
        o.res   = wide[WORD_W-1:0];
        o.carry = wide[WORD_W];
      end
      OPC_SUB: begin
        wide    = {1'b0, a} - {1'b0, b};
        o.res   = wide[WORD_W-1:0];
        o.carry = wide[WORD_W];
      end
      OPC_AND: o.res = a & b;
      OPC_OR:  o.res = a | b;
      OPC_XOR: o.res = a ^ b;
      OPC_SHL: o.res = a << b[SHAMT_W-1:0];
      OPC_SHR: o.res = a >> b[SHAMT_W-1:0];
      OPC_MOV: o.res = a;
      default: o.alu = 1'b0;
    endcase
    return o;
  endfunction

  function automatic logic cond_eval(input logic [COND_W-1:0] cond,
                                     input logic c, input logic z,
                                     input word_t a, input word_t b);
    logic ok;
    case (cond)
      CND_ALWAYS: ok = 1'b1;
      CND_C:      ok = c;
      CND_NC:     ok = !c;
      CND_Z:      ok = z;
      CND_NZ:     ok = !z;
      CND_C_OR_Z: ok = c | z;
      CND_NC_NZ:  ok = !c & !z;
      CND_EQ:     ok = (a == b);
      CND_NE:     ok = (a != b);
      CND_UGT:    ok = (a > b);
      CND_UGE:    ok = (a >= b);
      CND_ULT:    ok = (a < b);
      CND_ULE:    ok = (a <= b);
      CND_SGT:    ok = ($signed(a) > $signed(b));
      CND_SLT:    ok = ($signed(a) < $signed(b));
      default:    ok = 1'b0;
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/dwx_phase_seq.sv
module dwx_phase_seq
  import dwx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_t phase,
  output logic   in_fetch,
  output logic   in_oper,
  output logic   in_eval,
  output logic   in_write
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_FETCH;
    end else begin
      case (phase)
        PH_FETCH: phase <= PH_OPER;
        PH_OPER:  phase <= PH_EVAL;
        PH_EVAL:  phase <= PH_WRITE;
        default:  phase <= PH_FETCH;
      endcase
    end
  end

  assign in_fetch = (phase == PH_FETCH);
  assign in_oper  = (phase == PH_OPER);
  assign in_eval  = (phase == PH_EVAL);
  assign in_write = (phase == PH_WRITE);
endmodule

// File: rtl/dwx_operand_sel.sv
module dwx_operand_sel
  import dwx_pkg::*;
(
  input  head_t hd,
  input  tail_t tl,
  input  word_t mem_a,
  input  word_t mem_b,
  output word_t opa,
  output word_t opb
);
  localparam int PAD_W = WORD_W - FIELD_W;

  always_comb begin
    if (hd.lj) begin
      opa = {tl.s1, tl.s2};
      opb = '0;
    end else begin
      opa = hd.l1 ? {{PAD_W{1'b0}}, tl.s1} : mem_a;
      opb = hd.l2 ? {{PAD_W{1'b0}}, tl.s2} : mem_b;
    end
  end
endmodule

// File: rtl/dwx_exec_unit.sv
module dwx_exec_unit
  import dwx_pkg::*;
(
  input  logic [OPC_W-1:0]  opc,
  input  logic [COND_W-1:0] cond,
  input  logic              c_in,
  input  logic              z_in,
  input  word_t             opa,
  input  word_t             opb,
  output logic              pass,
  output alu_out_t          ao,
  output logic              is_jump
);
  always_comb begin
    pass    = cond_eval(cond, c_in, z_in, opa, opb);
    ao      = alu_eval(opc, opa, opb);
    is_jump = (opc == OPC_JMP);
  end
endmodule

// File: rtl/dw_exec_core.sv
module dw_exec_core
  import dwx_pkg::*;
#(
  parameter logic [15:0] RESET_PC = 16'h0000,
  parameter int          PC_STEP  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] a_addr,
  output logic        a_we,
  output logic [31:0] a_wdata,
  input  logic [31:0] a_rdata,
  output logic [15:0] b_addr,
  input  logic [31:0] b_rdata,
  output logic [15:0] pc,
  output logic        c_flag,
  output logic        z_flag
);
  localparam addr_t STEP_A = addr_t'(PC_STEP);
  localparam addr_t NEXT_W = addr_t'(1);

  phase_t   phase;
  logic     ev_fetch, ev_oper, ev_eval, ev_write;
  head_t    ir_hd;
  tail_t    ir_tl;
  tail_t    fetched_tl;
  word_t    opa, opb;
  logic     pass;
  alu_out_t ao;
  logic     jmp;

  word_t    res_q;
  logic     carry_q, alu_q, jump_q, pass_q;
  addr_t    jtgt_q;

  // named events for the checker
  logic     ev_commit, ev_jump, z_wr_en;

  dwx_phase_seq u_seq (
    .clk(clk), .rst_n(rst_n), .phase(phase),
    .in_fetch(ev_fetch), .in_oper(ev_oper), .in_eval(ev_eval), .in_write(ev_write)
  );

  dwx_operand_sel u_opsel (
    .hd(ir_hd), .tl(ir_tl), .mem_a(a_rdata), .mem_b(b_rdata), .opa(opa), .opb(opb)
  );

  dwx_exec_unit u_exec (
    .opc(ir_hd.opc), .cond(ir_hd.cond), .c_in(c_flag), .z_in(z_flag),
    .opa(opa), .opb(opb), .pass(pass), .ao(ao), .is_jump(jmp)
  );

  assign fetched_tl = tail_t'(b_rdata);

  // port addressing per phase; source fields taken straight from port B data
  always_comb begin
    a_addr = pc;
    b_addr = pc + NEXT_W;
    case (phase)
      PH_OPER: begin
        a_addr = fetched_tl.s1;
        b_addr = fetched_tl.s2;
      end
      PH_WRITE: a_addr = ir_hd.dst;
      default: ;
    endcase
  end

  assign ev_commit = ev_write & pass_q & alu_q;
  assign ev_jump   = ev_write & pass_q & jump_q;
  assign z_wr_en   = ir_hd.wz;
  assign a_we      = ev_commit;
  assign a_wdata   = res_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir_hd   <= '0;
      ir_tl   <= '0;
      res_q   <= '0;
      carry_q <= 1'b0;
      alu_q   <= 1'b0;
      jump_q  <= 1'b0;
      pass_q  <= 1'b0;
      jtgt_q  <= '0;
      pc      <= RESET_PC;
      c_flag  <= 1'b0;
      z_flag  <= 1'b0;
    end else begin
      if (ev_oper) begin
        ir_hd <= head_t'(a_rdata);
        ir_tl <= fetched_tl;
      end
      if (ev_eval) begin
        res_q   <= ao.res;
        carry_q <= ao.carry;
        alu_q   <= ao.alu;
        jump_q  <= jmp;
        pass_q  <= pass;
        jtgt_q  <= opa[FIELD_W-1:0];
      end
      if (ev_write) begin
        pc <= ev_jump ? jtgt_q : pc + STEP_A;
        if (ev_commit && ir_hd.wc) c_flag <= carry_q;
        if (ev_commit && ir_hd.wz) z_flag <= (res_q == '0);
      end
    end
  end
endmodule

// File: rtl/dwx_checker.sv
module dwx_checker
  import dwx_pkg::*;
#(
  parameter logic [15:0] RESET_PC = 16'h0000,
  parameter int          PC_STEP  = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] a_addr,
  input logic        a_we,
  input logic [31:0] a_wdata,
  input logic [15:0] b_addr,
  input logic [15:0] pc,
  input logic        c_flag,
  input logic        z_flag,
  input logic        ev_fetch,
  input logic        ev_oper,
  input logic        ev_eval,
  input logic        ev_write,
  input logic        ev_commit,
  input logic        ev_jump,
  input logic        z_wr_en
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pc == RESET_PC && !c_flag && !z_flag && !a_we)); // R1
  AST_WE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    a_we |-> ev_write); // R2
  AST_FETCH_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch |-> (a_addr == pc && b_addr == pc + 16'd1)); // R2
  AST_PHASE_RING: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write |=> ev_fetch); // R2
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ev_fetch, ev_oper, ev_eval, ev_write}) == 1); // R2
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_write && !ev_jump) |=> pc == $past(pc) + 16'(PC_STEP)); // R12
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_write |=> $stable(pc)); // R12
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_commit |=> $stable({c_flag, z_flag})); // R9
  AST_Z_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_commit && z_wr_en) |=> z_flag == ($past(a_wdata) == 32'd0)); // R8
endmodule

bind dw_exec_core dwx_checker #(.RESET_PC(RESET_PC), .PC_STEP(PC_STEP)) u_dwx_chk (
  .clk(clk), .rst_n(rst_n), .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata),
  .b_addr(b_addr), .pc(pc), .c_flag(c_flag), .z_flag(z_flag),
  .ev_fetch(ev_fetch), .ev_oper(ev_oper), .ev_eval(ev_eval), .ev_write(ev_write),
  .ev_commit(ev_commit), .ev_jump(ev_jump), .z_wr_en(z_wr_en)
);

// File: tb/test_dw_exec_core.sv
`timescale 1ns/1ps
module test_dw_exec_core;
  localparam logic [15:0] P0 = 16'h0040;
  localparam int MEM_D = 1024;
  localparam logic [31:0] SENT = 32'hA5A5_A5A5;

  localparam int ADD = 1, SUB = 2, AND_ = 3, OR_ = 4, XOR_ = 5, SHL = 6, SHR = 7, MOV = 8, JMP = 9;
  localparam int NEV = 0, ALW = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a_addr, b_addr, pc;
  logic        a_we, c_flag, z_flag;
  logic [31:0] a_wdata, a_rdata, b_rdata;
  logic [31:0] ram [0:MEM_D-1];

  int n_chk = 0;
  int n_fail = 0;

  logic        exp_w [0:16];
  logic [31:0] exp_v [0:16];

  always #5 clk = ~clk;

  dw_exec_core #(.RESET_PC(P0), .PC_STEP(2)) i_dw_exec_core (
    .clk(clk), .rst_n(rst_n), .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .b_addr(b_addr), .b_rdata(b_rdata), .pc(pc),
    .c_flag(c_flag), .z_flag(z_flag)
  );

  // dual-port memory model, synchronous read-first, upper address bits folded
  always @(posedge clk) begin
    if (a_we) ram[a_addr[9:0]] <= a_wdata;
    a_rdata <= ram[a_addr[9:0]];
    b_rdata <= ram[b_addr[9:0]];
  end

  function automatic logic [31:0] hw(input int op, input bit wc, input bit wz, input bit l1,
                                     input bit l2, input bit lj, input int cond, input int dst);
    return {op[5:0], wc, wz, l1, l2, lj, cond[4:0], dst[15:0]};
  endfunction

  function automatic logic [31:0] tw(input int s1, input int s2);
    return {s1[15:0], s2[15:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(input int addr, input logic [31:0] w0, input logic [31:0] w1);
    ram[addr % MEM_D] = w0;
    ram[(addr + 1) % MEM_D] = w1;
  endtask

  task automatic begin_test();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < MEM_D; i++) ram[i] = 32'd0;
  endtask

  task automatic start_core();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(input int n);
    repeat (4 * n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    begin_test();
    chk("R1 pc in reset", {16'd0, pc}, {16'd0, P0});
    start_core();
    chk("R1 pc after reset", {16'd0, pc}, {16'd0, P0});
    chk("R1 flags after reset", {30'd0, c_flag, z_flag}, 32'd0);
    chk("R1 no write after reset", {31'd0, a_we}, 32'd0);
    run(1);
    chk("R11 opcode zero advances pc", {16'd0, pc}, {16'd0, P0 + 16'd2});
  endtask

  task automatic t_literal_arith();
    begin_test();
    ram[16'h200] = SENT; ram[16'h201] = SENT; ram[16'h202] = SENT;
    put(P0,     hw(ADD, 1, 1, 1, 1, 0, ALW, 16'h200), tw(16'h1234, 16'h0011));
    put(P0 + 2, hw(SUB, 1, 1, 1, 1, 0, ALW, 16'h201), tw(5, 5));
    put(P0 + 4, hw(SUB, 1, 0, 1, 1, 0, ALW, 16'h202), tw(3, 5));
    start_core();
    run(1);
    chk("R4 add of two literals", ram[16'h200], 32'h0000_1245);
    chk("R8 add no carry, nonzero", {30'd0, c_flag, z_flag}, 32'd0);
    run(1);
    chk("R8 sub equal gives zero", ram[16'h201], 32'd0);
    chk("R8 Z set, no borrow", {30'd0, c_flag, z_flag}, 32'd1);
    run(1);
    chk("R7 sub wraps", ram[16'h202], 32'hFFFF_FFFE);
    chk("R9 borrow set, Z kept with enable off", {30'd0, c_flag, z_flag}, 32'd3);
  endtask

  task automatic t_memory_ops();
    begin_test();
    ram[16'h300] = 32'hFFFF_FFFF;
    ram[16'h301] = 32'h0000_0001;
    ram[16'h303] = 32'hF0F0_00FF;
    put(P0,      hw(ADD,  1, 1, 0, 0, 0, ALW, 16'h302), tw(16'h300, 16'h301));
    put(P0 + 2,  hw(AND_, 1, 1, 0, 1, 0, ALW, 16'h304), tw(16'h303, 16'h0FF0));
    put(P0 + 4,  hw(OR_,  0, 0, 1, 1, 0, ALW, 16'h305), tw(16'h00F0, 16'h000F));
    put(P0 + 6,  hw(SHL,  0, 0, 0, 1, 0, ALW, 16'h306), tw(16'h301, 31));
    put(P0 + 8,  hw(SHR,  0, 0, 0, 1, 0, ALW, 16'h307), tw(16'h300, 4));
    put(P0 + 10, hw(XOR_, 1, 1, 1, 1, 0, ALW, 16'h308), tw(16'hFFFF, 16'h00FF));
    start_core();
    run(1);
    chk("R6 add of memory operands", ram[16'h302], 32'd0);
    chk("R8 carry out and zero", {30'd0, c_flag, z_flag}, 32'd3);
    run(5);
    chk("R4 memory A with literal B", ram[16'h304], 32'h0000_00F0);
    chk("R7 or", ram[16'h305], 32'h0000_00FF);
    chk("R7 shift left by 31", ram[16'h306], 32'h8000_0000);
    chk("R7 logical shift right", ram[16'h307], 32'h0FFF_FFFF);
    chk("R7 xor", ram[16'h308], 32'h0000_FF00);
    chk("R8 logic op clears C, nonzero clears Z", {30'd0, c_flag, z_flag}, 32'd0);
  endtask

  task automatic t_joined();
    begin_test();
    put(P0,     hw(MOV, 0, 0, 1, 1, 1, ALW, 16'h280), tw(16'hDEAD, 16'hBEEF));
    put(P0 + 2, hw(ADD, 1, 1, 0, 0, 1, ALW, 16'h281), tw(16'hFFFF, 16'hFFFF));
    start_core();
    run(2);
    chk("R5 joined literal overrides single flags", ram[16'h280], 32'hDEAD_BEEF);
    chk("R5 joined literal plus zero B", ram[16'h281], 32'hFFFF_FFFF);
    chk("R5 flags of joined add", {30'd0, c_flag, z_flag}, 32'd0);
  endtask

  task automatic cm(input int k, input int cond, input bit l1, input bit l2,
                    input int s1, input int s2, input bit w, input logic [31:0] v);
    put(P0 + 2 * k, hw(MOV, 0, 0, l1, l2, 0, cond, 16'h210 + k), tw(s1, s2));
    ram[16'h210 + k] = SENT;
    exp_w[k] = w;
    exp_v[k] = w ? v : SENT;
  endtask

  task automatic t_conditions();
    begin_test();
    ram[16'h2E0] = 32'hFFFF_FFFF;
    put(P0, hw(SUB, 1, 1, 1, 1, 0, ALW, 16'h2F0), tw(3, 5));
    cm(1,  2,  1, 0, 1, 0, 1, 1);
    cm(2,  3,  1, 0, 2, 0, 0, 2);
    cm(3,  4,  1, 0, 3, 0, 0, 3);
    cm(4,  5,  1, 0, 4, 0, 1, 4);
    cm(5,  6,  1, 0, 5, 0, 1, 5);
    cm(6,  7,  1, 0, 6, 0, 0, 6);
    cm(7,  8,  1, 1, 7, 7, 1, 7);
    cm(8,  9,  1, 1, 7, 7, 0, 7);
    cm(9,  10, 1, 1, 9, 7, 1, 9);
    cm(10, 11, 1, 1, 7, 9, 0, 7);
    cm(11, 12, 1, 1, 7, 9, 1, 7);
    cm(12, 13, 1, 1, 9, 7, 0, 9);
    cm(13, 14, 0, 1, 16'h2E0, 1, 0, 32'hFFFF_FFFF);
    cm(14, 15, 0, 1, 16'h2E0, 1, 1, 32'hFFFF_FFFF);
    cm(15, 16, 1, 0, 15, 0, 0, 15);
    cm(16, 31, 1, 0, 16, 0, 0, 16);
    start_core();
    run(17);
    chk("R10 setup flags C=1 Z=0", {30'd0, c_flag, z_flag}, 32'd2);
    for (int k = 1; k <= 16; k++) begin
      chk($sformatf("R10 condition case %0d", k), ram[16'h210 + k], exp_v[k]);
    end
    chk("R12 pc after seventeen steps", {16'd0, pc}, {16'd0, P0 + 16'd34});
  endtask

  task automatic t_no_effect();
    begin_test();
    ram[16'h300] = 32'hFFFF_FFFF;
    ram[16'h301] = 32'h0000_0001;
    ram[16'h240] = SENT; ram[16'h241] = SENT; ram[16'h242] = SENT;
    put(P0,     hw(ADD, 1, 1, 0, 0, 0, ALW, 16'h2F1), tw(16'h300, 16'h301));
    put(P0 + 2, hw(ADD, 1, 1, 1, 1, 0, NEV, 16'h240), tw(1, 1));
    put(P0 + 4, hw(0,   1, 1, 1, 1, 0, ALW, 16'h241), tw(1, 1));
    put(P0 + 6, hw(63,  1, 1, 1, 1, 0, ALW, 16'h242), tw(1, 1));
    start_core();
    run(2);
    chk("R11 never: no write", ram[16'h240], SENT);
    chk("R11 never: flags kept", {30'd0, c_flag, z_flag}, 32'd3);
    chk("R11 never: pc advances", {16'd0, pc}, {16'd0, P0 + 16'd4});
    run(1);
    chk("R11 opcode zero: no write", ram[16'h241], SENT);
    chk("R11 opcode zero: flags kept", {30'd0, c_flag, z_flag}, 32'd3);
    run(1);
    chk("R11 unused opcode: no write", ram[16'h242], SENT);
    chk("R11 unused opcode: flags kept", {30'd0, c_flag, z_flag}, 32'd3);
    chk("R11 unused opcode: pc advances", {16'd0, pc}, {16'd0, P0 + 16'd8});
  endtask

  task automatic t_jump();
    begin_test();
    ram[16'h310] = 32'h0001_FFFE;
    ram[16'h220] = SENT;
    put(P0,      hw(SUB, 1, 1, 1, 1, 0, ALW, 16'h2F2), tw(5, 5));
    put(P0 + 2,  hw(JMP, 1, 1, 1, 0, 0, ALW, 0), tw(16'h0100, 0));
    put(16'h100, hw(JMP, 0, 0, 1, 0, 0, 2, 0), tw(16'h0200, 0));
    put(16'h102, hw(JMP, 0, 0, 0, 0, 0, ALW, 0), tw(16'h310, 0));
    put(16'hFFFE, hw(MOV, 0, 0, 1, 0, 0, ALW, 16'h220), tw(16'h0077, 0));
    start_core();
    run(2);
    chk("R12 jump loads literal target", {16'd0, pc}, 32'h0000_0100);
    chk("R12 jump leaves flags", {30'd0, c_flag, z_flag}, 32'd1);
    run(1);
    chk("R12 untaken jump steps by two", {16'd0, pc}, 32'h0000_0102);
    run(1);
    chk("R12 jump from memory keeps low 16 bits", {16'd0, pc}, 32'h0000_FFFE);
    run(1);
    chk("R12 pc wraps past FFFE", {16'd0, pc}, 32'h0000_0000);
    chk("R3 code at top of space ran", ram[16'h220], 32'h0000_0077);
  endtask

  task automatic t_timing();
    begin_test();
    for (int i = 0; i < 3; i++) begin
      put(P0 + 2 * i, hw(MOV, 0, 0, 1, 0, 0, ALW, 16'h230 + i), tw(16'h10 + i, 0));
    end
    start_core();
    for (int k = 1; k <= 12; k++) begin
      chk($sformatf("R2 write enable in cycle %0d", k), {31'd0, a_we}, {31'd0, (k % 4) == 0});
      if ((k % 4) == 1) begin
        chk("R2 fetch address A", {16'd0, a_addr}, {16'd0, P0 + 16'(2 * (k / 4))});
        chk("R2 fetch address B", {16'd0, b_addr}, {16'd0, P0 + 16'(2 * (k / 4) + 1)});
      end
      if ((k % 4) == 0) begin
        chk("R2 write goes to destination", {16'd0, a_addr}, 32'h230 + 32'(k / 4 - 1));
      end
      @(negedge clk);
    end
    chk("R3 third move landed", ram[16'h232], 32'h0000_0012);
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_literal_arith();
    t_memory_ops();
    t_joined();
    t_conditions();
    t_no_effect();
    t_jump();
    t_timing();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule